// File: doc/BRIEF.md
# Auto-Reload Interval Timer

The block is a 12-bit up-counter for periodic events. When the count passes its all-ones value it does not wrap to zero. It loads a programmable reload value and counts on from there. So the period, in counter ticks, is set by software. A prescale selector takes the counter tick from the system clock. The tick can be stopped, taken from an external slow tick pulse, taken from every system clock, or taken from every second system clock.

An 8-bit control/status register holds the following:
- the tick select;
- the sticky overflow flag;
- two interrupt enables.

A second 12-bit register sets a compare point. Reaching it raises a sticky compare flag. The overflow flag is cleared by reading the control/status register, but only after one more counter tick. Each flag, gated by its enable, drives its own request line. A wake output tells the power controller when a request may end the current low-power mode.

Software uses a simple byte-wide register bus with a select, a write strobe and a 3-bit address. Reads are combinational. Read side effects take place at the clock edge that ends the access.

Top module: `art_timer`

## Requirements
- R1: After reset, every register reads 00h, the count is 0, and irq_ovf_o, irq_cmp_o and wake_o are low.
- R2: The control/status register (address 0) reads {000, tick select[4:3], ovf flag[2], ovf enable[1], cmp enable[0]}. A write changes only bits 4:3, 1 and 0, and never changes the ovf flag.
- R3: Tick select: 00 = no ticks; 01 = one tick per slow_tick_i pulse; 10 = a tick on every clock; 11 = a tick on every second clock, driven by a free-running divider that is cleared at reset.
- R4: Each tick adds 1 to the count. A tick at FFFh loads the reload value instead and sets the ovf flag.
- R5: A reload write changes neither the count nor the current period. The new value is loaded at the next overflow.
- R6: A read of address 0 while the ovf flag is set arms a clear. The flag drops at the next tick, or on the next clock if the select is 00. An overflow at that tick keeps the flag set.
- R7: A tick that makes the count equal the compare value sets the cmp flag (address 5, bit 0). A read of address 5 clears it, unless a compare event arrives at the same edge.
- R8: irq_ovf_o = ovf flag AND ovf enable; irq_cmp_o = cmp flag AND cmp enable.
- R9: lp_mode_i 00 (run): wake_o is 0. 01 (wait): wake_o is irq_ovf_o OR irq_cmp_o. 10 (active-halt): wake_o is irq_ovf_o, but only while the tick select is 01. 11 (halt): wake_o is 0.
- R10: Address map. 1/2 = reload low byte / high nibble. 3/4 = compare low byte / high nibble. 5 = cmp status. 6/7 = count low byte / high nibble, read-only. Writes to 5, 6 and 7 are ignored. Unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | One-cycle pulses of the fixed slow tick |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| lp_mode_i | input | 2 | Current power mode: 00 run, 01 wait, 10 active-halt, 11 halt |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cmp_o | output | 1 | Compare interrupt request |
| wake_o | output | 1 | Wake request for the current power mode |

## Verification
The counter runs under each tick source: stopped, slow pulses, full rate and half rate. Each source gives a different overflow spacing, so a wrong divider or a wrong select decode shifts every later overflow.

The overflow flag is read at several distances from a tick. These reads separate a clear that happens at once from one that waits for the next tick.

The reload value is rewritten mid-period. This shows whether a write disturbs the running count.

While all of this runs, the power mode is swept through all four codes. This exposes any wake path that ignores the select or lets the compare request through in active-halt.

// File: rtl/art_pkg.sv
package art_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam int CSR_CMPIE  = 0;
  localparam int CSR_OVFIE  = 1;
  localparam int CSR_OVF    = 2;
  localparam int CSR_CK_LSB = 3;

  typedef enum logic [1:0] {
    CK_OFF  = 2'b00,
    CK_SLOW = 2'b01,
    CK_SYS  = 2'b10,
    CK_HALF = 2'b11
  } ck_sel_e;

  typedef enum logic [1:0] {
    LP_RUN   = 2'b00,
    LP_WAIT  = 2'b01,
    LP_AHALT = 2'b10,
    LP_HALT  = 2'b11
  } lp_mode_e;

  typedef enum logic [ADDR_W-1:0] {
    A_CSR     = 3'd0,
    A_RLD_LO  = 3'd1,
    A_RLD_HI  = 3'd2,
    A_CMP_LO  = 3'd3,
    A_CMP_HI  = 3'd4,
    A_CMP_STS = 3'd5,
    A_CNT_LO  = 3'd6,
    A_CNT_HI  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/art_prescale.sv
module art_prescale
  import art_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ck_sel_e sel_i,
  input  logic    slow_tick_i,
  output logic    tick_o
);
  logic phase_q;

  // free-running divide-by-2 phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  always_comb begin
    case (sel_i)
      CK_SLOW: tick_o = slow_tick_i;
      CK_SYS:  tick_o = 1'b1;
      CK_HALF: tick_o = phase_q;
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/art_counter.sv
module art_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_evt_o,
  output logic             cmp_evt_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign ovf_evt_o = tick_i && (cnt_q == CNT_TOP);
  assign cnt_nxt   = (cnt_q == CNT_TOP) ? reload_i : cnt_q + 1'b1;
  assign cmp_evt_o = tick_i && (cnt_nxt == cmp_i);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/art_wake.sv
module art_wake
  import art_pkg::*;
(
  input  lp_mode_e mode_i,
  input  ck_sel_e  ck_i,
  input  logic     irq_ovf_i,
  input  logic     irq_cmp_i,
  output logic     wake_o
);
  always_comb begin
    case (mode_i)
      LP_WAIT:  wake_o = irq_ovf_i | irq_cmp_i;
      LP_AHALT: wake_o = irq_ovf_i && (ck_i == CK_SLOW); // only the slow tick runs here
      default:  wake_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/art_timer.sv
module art_timer
  import art_pkg::*;
#(
  parameter int CNT_W = 12  // DATA_W < CNT_W <= 2*DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        lp_mode_i,
  output logic              irq_ovf_o,
  output logic              irq_cmp_o,
  output logic              wake_o
);
  localparam int HI_W = CNT_W - DATA_W;

  ck_sel_e          ck_q;
  logic             ovfie_q, cmpie_q, ovf_q, pend_q, cmpf_q;
  logic [CNT_W-1:0] arr_q, cmp_q, cnt;
  logic             tick, ovf_evt, cmp_evt, wr, rd;
  reg_addr_e        addr;

  assign wr   = sel_i & we_i;
  assign rd   = sel_i & ~we_i;
  assign addr = reg_addr_e'(addr_i);

  art_prescale u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (ck_q),
    .slow_tick_i (slow_tick_i),
    .tick_o      (tick)
  );

  art_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .reload_i  (arr_q),
    .cmp_i     (cmp_q),
    .cnt_o     (cnt),
    .ovf_evt_o (ovf_evt),
    .cmp_evt_o (cmp_evt)
  );

  // software-written registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q    <= CK_OFF;
      ovfie_q <= 1'b0;
      cmpie_q <= 1'b0;
      arr_q   <= '0;
      cmp_q   <= '0;
    end else if (wr) begin
      case (addr)
        A_CSR: begin
          ck_q    <= ck_sel_e'(wdata_i[CSR_CK_LSB+:2]);
          ovfie_q <= wdata_i[CSR_OVFIE];
          cmpie_q <= wdata_i[CSR_CMPIE];
        end
        A_RLD_LO: arr_q[DATA_W-1:0]     <= wdata_i;
        A_RLD_HI: arr_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
        A_CMP_LO: cmp_q[DATA_W-1:0]     <= wdata_i;
        A_CMP_HI: cmp_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
        default: ;
      endcase
    end
  end

  // overflow flag: read arms a clear that lands on the next counter tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (ovf_evt) begin
      ovf_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (pend_q && (tick || ck_q == CK_OFF)) begin
        ovf_q  <= 1'b0;
        pend_q <= 1'b0;
      end
      if (rd && addr == A_CSR && ovf_q) pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cmpf_q <= 1'b0;
    else if (cmp_evt)                  cmpf_q <= 1'b1;
    else if (rd && addr == A_CMP_STS)  cmpf_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr)
      A_CSR: begin
        rdata_o[CSR_CK_LSB+:2] = ck_q;
        rdata_o[CSR_OVF]       = ovf_q;
        rdata_o[CSR_OVFIE]     = ovfie_q;
        rdata_o[CSR_CMPIE]     = cmpie_q;
      end
      A_RLD_LO:  rdata_o = arr_q[DATA_W-1:0];
      A_RLD_HI:  rdata_o = DATA_W'(arr_q[CNT_W-1:DATA_W]);
      A_CMP_LO:  rdata_o = cmp_q[DATA_W-1:0];
      A_CMP_HI:  rdata_o = DATA_W'(cmp_q[CNT_W-1:DATA_W]);
      A_CMP_STS: rdata_o[0] = cmpf_q;
      A_CNT_LO:  rdata_o = cnt[DATA_W-1:0];
      A_CNT_HI:  rdata_o = DATA_W'(cnt[CNT_W-1:DATA_W]);
      default: ;
    endcase
  end

  assign irq_ovf_o = ovf_q & ovfie_q;
  assign irq_cmp_o = cmpf_q & cmpie_q;

  art_wake u_wake (
    .mode_i    (lp_mode_e'(lp_mode_i)),
    .ck_i      (ck_q),
    .irq_ovf_i (irq_ovf_o),
    .irq_cmp_i (irq_cmp_o),
    .wake_o    (wake_o)
  );
endmodule

// File: rtl/art_timer_chk.sv
module art_timer_chk
  import art_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        lp_mode_i,
  input logic [1:0]        ck_q,
  input logic              tick,
  input logic              ovf_evt,
  input logic              cmp_evt,
  input logic              ovf_q,
  input logic              cmpf_q,
  input logic              irq_ovf_o,
  input logic              irq_cmp_o,
  input logic              wake_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  arr_q
);
  // R4
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> ovf_q);

  // R4
  reload_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> cnt == $past(arr_q));

  // R2
  ovf_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(ovf_evt));

  // R3
  ck_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ck_q == 2'b00 |-> !tick);

  // R3
  half_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ck_q == 2'b11) |=> !(tick && ck_q == 2'b11));

  // R5
  reload_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && (addr_i == 3'd1 || addr_i == 3'd2) && !tick) |=> $stable(cnt));

  // R7
  cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt |=> cmpf_q);

  // R9
  halt_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_mode_i == 2'b11 |-> !wake_o);

  // R9
  ahalt_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i == 2'b10 && ck_q != 2'b01) |-> !wake_o);

  // R9
  wait_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i == 2'b01 && (irq_ovf_o || irq_cmp_o)) |-> wake_o);
endmodule

bind art_timer art_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .lp_mode_i (lp_mode_i),
  .ck_q      (ck_q),
  .tick      (tick),
  .ovf_evt   (ovf_evt),
  .cmp_evt   (cmp_evt),
  .ovf_q     (ovf_q),
  .cmpf_q    (cmpf_q),
  .irq_ovf_o (irq_ovf_o),
  .irq_cmp_o (irq_cmp_o),
  .wake_o    (wake_o),
  .cnt       (cnt),
  .arr_q     (arr_q)
);

// File: tb/tb_art_timer.sv
module tb_art_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_tick = 1'b0;
  logic       sel = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] lp_mode = '0;
  logic       irq_ovf, irq_cmp, wake;

  int n_chk = 0, n_err = 0;
  int slow_cnt = 0;
  bit done = 1'b0;

  // reference model state
  int m_cnt, m_arr, m_cmp, m_ck, m_ovfie, m_cmpie, m_ovf, m_pend, m_cmpf, m_phase;
  int t, oe, ce, nxt, n_ovf, n_pend, rdv, wrv;

  always #10 clk = ~clk;

  art_timer dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .slow_tick_i (slow_tick),
    .sel_i       (sel),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .lp_mode_i   (lp_mode),
    .irq_ovf_o   (irq_ovf),
    .irq_cmp_o   (irq_cmp),
    .wake_o      (wake)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rd_model(input int a);
    case (a)
      0: return (m_ck << 3) | (m_ovf << 2) | (m_ovfie << 1) | m_cmpie;
      1: return m_arr & 255;
      2: return m_arr >> 8;
      3: return m_cmp & 255;
      4: return m_cmp >> 8;
      5: return m_cmpf;
      6: return m_cnt & 255;
      default: return m_cnt >> 8;
    endcase
  endfunction

  // slow tick: one pulse every fifth clock
  always @(negedge clk) begin
    slow_cnt  <= (slow_cnt == 4) ? 0 : slow_cnt + 1;
    slow_tick <= (slow_cnt == 4);
  end

  // behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_arr = 0; m_cmp = 0; m_ck = 0; m_ovfie = 0; m_cmpie = 0;
      m_ovf = 0; m_pend = 0; m_cmpf = 0; m_phase = 0;
    end else begin
      case (m_ck)
        1: t = int'(slow_tick);
        2: t = 1;
        3: t = m_phase;
        default: t = 0;
      endcase
      rdv = int'(sel && !we);
      wrv = int'(sel && we);
      oe  = int'(t != 0 && m_cnt == 4095);
      nxt = (m_cnt == 4095) ? m_arr : m_cnt + 1;
      ce  = int'(t != 0 && nxt == m_cmp);
      n_ovf = m_ovf; n_pend = m_pend;
      if (oe != 0) begin
        n_ovf = 1; n_pend = 0;
      end else begin
        if (m_pend != 0 && (t != 0 || m_ck == 0)) begin n_ovf = 0; n_pend = 0; end
        if (rdv != 0 && addr == 0 && m_ovf != 0) n_pend = 1;
      end
      if (ce != 0) m_cmpf = 1;
      else if (rdv != 0 && addr == 5) m_cmpf = 0;
      m_ovf = n_ovf; m_pend = n_pend;
      if (t != 0) m_cnt = nxt;
      if (wrv != 0) begin
        case (addr)
          0: begin m_ck = int'(wdata[4:3]); m_ovfie = int'(wdata[1]); m_cmpie = int'(wdata[0]); end
          1: m_arr = (m_arr & 32'hF00) | int'(wdata);
          2: m_arr = (m_arr & 32'h0FF) | (int'(wdata[3:0]) << 8);
          3: m_cmp = (m_cmp & 32'hF00) | int'(wdata);
          4: m_cmp = (m_cmp & 32'h0FF) | (int'(wdata[3:0]) << 8);
          default: ;
        endcase
      end
      m_phase = 1 - m_phase;
    end
  end

  // per-cycle comparison of request and wake lines
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      int e_ovf, e_cmp, e_wake;
      e_ovf = m_ovf & m_ovfie;
      e_cmp = m_cmpf & m_cmpie;
      case (lp_mode)
        2'b01:   e_wake = e_ovf | e_cmp;
        2'b10:   e_wake = (m_ck == 1) ? e_ovf : 0;
        default: e_wake = 0;
      endcase
      check("R8 irq_ovf", int'(irq_ovf), e_ovf);   // also covers R4 R6 timing
      check("R8 irq_cmp", int'(irq_cmp), e_cmp);   // also covers R7
      check("R9 wake", int'(wake), e_wake);
    end
  end

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input int a, input string req);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = 3'(a);
    #1 check(req, int'(rdata), rd_model(a));
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic run(input int n, input int lp_step);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lp_mode = 2'((i / lp_step) % 4);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state through every address
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); addr = 3'(a); #1 check("R1 reset value", int'(rdata), 0);
    end
    check("R1 irq/wake idle", int'({irq_ovf, irq_cmp, wake}), 0);

    // R2 writable bits only
    bus_wr(0, 8'hFF);
    bus_rd(0, "R2 csr layout");
    bus_wr(0, 8'h00);
    bus_rd(6, "R3 stopped count");
    run(20, 100);
    bus_rd(6, "R3 stopped count unchanged");

    // R10 map
    bus_wr(1, 8'hF0); bus_wr(2, 8'h0F);
    bus_wr(3, 8'hF8); bus_wr(4, 8'hFF);
    for (int a = 1; a < 5; a++) bus_rd(a, "R10 readback");

    // full rate, both enables
    bus_wr(0, 8'h13);
    run(4150, 37);
    bus_rd(0, "R4 ovf set R6");
    bus_rd(0, "R6 ovf pending");
    run(5, 100);
    bus_rd(0, "R6 ovf after tick");
    bus_rd(6, "R4 count lo");
    bus_rd(7, "R4 count hi");
    bus_rd(5, "R7 cmp flag");
    bus_rd(5, "R7 cmp flag cleared");
    // R5 reload rewrite mid-period
    bus_rd(6, "R5 count before");
    bus_wr(1, 8'hFA);
    bus_rd(6, "R5 count after");
    run(60, 13);
    bus_rd(1, "R5 reload lo");

    // slow tick, reads at varied spacing
    bus_wr(0, 8'h0B);
    for (int k = 0; k < 12; k++) begin
      run(17 + k, 7);
      bus_rd(0, "R6 slow clear");
      bus_rd(6, "R3 slow count");
    end
    run(200, 11);

    // half rate
    bus_wr(0, 8'h1B);
    for (int k = 0; k < 6; k++) begin
      run(13 + k, 5);
      bus_rd(0, "R6 half clear");
      bus_rd(6, "R3 half count");
    end

    // ignored writes (R10) and ovf bit not writable (R2)
    bus_wr(0, 8'h03);
    bus_wr(5, 8'hFF); bus_rd(5, "R10 cmp sts write ignored");
    bus_wr(6, 8'hAA); bus_rd(6, "R10 count lo write ignored");
    bus_wr(7, 8'h55); bus_rd(7, "R10 count hi write ignored");
    bus_rd(0, "R2 clear under stopped select");
    bus_rd(0, "R6 stopped clear");
    bus_wr(0, 8'h07);
    bus_rd(0, "R2 ovf not writable");
    run(10, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule